// File: doc/BRIEF.md
# Instruction Cache Saturation Detector

This block observes the per-cycle lookup results of one core's L1 instruction cache. From them it decides two things. The first is whether the running thread has already filled the local cache with its code. The second is whether that thread has since moved on to a code region the cache does not hold. When both conditions hold, it requests a search of the other cores' caches for the code the thread now needs.

Detection has two stages. A saturating miss counter accumulates every miss. Once the counter reaches the programmed fill threshold, the cache counts as full and a 32-entry sliding record of recent lookups starts to collect one bit per lookup (1 for a miss, 0 for a hit). While the cache is full, a dense burst of misses in that record (at least the programmed dilution threshold) marks a new code segment and enables the remote search. A pulse signalling that the thread has finished migrating restarts both stages. Both thresholds are captured once, on the first clock edge after reset is released.

Top module: `icache_saturation_detector`

## Requirements
- R1: Each clock edge with lookup_vld_i high and lookup_miss_i high adds exactly one to the miss count. Hits, and cycles with lookup_vld_i low, leave the count unchanged.
- R2: The miss count saturates at 2^CNT_W-1 (1023 by default) and never wraps back to a lower value.
- R3: cache_full_o is high exactly when the miss count is greater than or equal to the captured fill threshold.
- R4: The window is WIN bits wide (32 by default). It shifts in lookup_miss_i (1 = miss, 0 = hit), with the newest lookup at bit 0 and the oldest dropped, only on edges where lookup_vld_i is high and cache_full_o was high before that edge.
- R5: new_seg_o is high exactly when cache_full_o is high and the number of ones in the window is greater than or equal to the captured dilution threshold.
- R6: search_en_o equals new_seg_o, except that it is held low in any cycle where migrate_done_i is high.
- R7: An edge with migrate_done_i high clears the miss count and the window, and takes priority over a lookup on the same edge.
- R8: Both thresholds are captured on the first clock edge after rst_ni rises. Later changes on fill_thresh_i or dil_thresh_i have no effect until the next reset.
- R9: While rst_ni is low, all three outputs are low.
- R10: The fill threshold accepts any value from 0 to 1023 (this covers 128 to 512), and the dilution threshold any value from 0 to WIN (this covers 2 to 30).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_vld_i | input | 1 | An instruction cache lookup completes this cycle |
| lookup_miss_i | input | 1 | Lookup result, 1 = miss, 0 = hit |
| migrate_done_i | input | 1 | Thread migration finished, restart detection |
| fill_thresh_i | input | CNT_W | Miss count at which the cache counts as full |
| dil_thresh_i | input | $clog2(WIN+1) | Miss density in the window that marks a new segment |
| cache_full_o | output | 1 | Local cache holds the thread's code |
| new_seg_o | output | 1 | Thread has entered a new code segment |
| search_en_o | output | 1 | Enable for the remote segment search |

## Verification
Random lookup streams are run at several miss densities. Low densities keep the window count under the dilution threshold, while dense streams cross it, so these runs separate a correct window count from an off-by-one or a wrong comparison. Directed runs count misses up to just below and exactly at the fill threshold, with hits and idle cycles between them. They also feed misses before the cache is full to show that the window ignores them, then send hits in a row to find the exact edge where the oldest miss leaves the 32-bit window. A stream of more than 1023 misses at the top threshold exposes a counter that wraps. Migration pulses sent in the middle of a stream, and threshold changes made after reset, show that clearing works and that the thresholds stay captured.

// File: rtl/icsd_pkg.sv
package icsd_pkg;
  // Default miss counter width: fill thresholds up to 1023
  localparam int unsigned ICSD_CNT_W = 10;
  // Default depth of the recent-lookup window
  localparam int unsigned ICSD_WIN   = 32;
endpackage

// File: rtl/icsd_miss_counter.sv
module icsd_miss_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | (inc_i & (cnt_q != CNT_MAX));
    cnt_d  = clr_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/icsd_miss_window.sv
module icsd_miss_window #(
  parameter int unsigned WIN   = 32,
  parameter int unsigned POP_W = $clog2(WIN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [WIN-1:0]   vec_o,
  output logic [POP_W-1:0] pop_o
);
  logic [WIN-1:0]   vec_q, vec_d;
  logic             vec_en;
  logic [POP_W-1:0] psum [WIN+1];

  always_comb begin
    vec_en = clr_i | shift_i;
    vec_d  = clr_i ? '0 : {vec_q[WIN-2:0], bit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vec_q <= '0;
    else if (vec_en) vec_q <= vec_d;
  end

  // Running population count over the window bits
  assign psum[0] = '0;
  for (genvar g = 0; g < WIN; g++) begin : g_pop
    assign psum[g+1] = psum[g] + POP_W'(vec_q[g]);
  end

  assign vec_o = vec_q;
  assign pop_o = psum[WIN];
endmodule

// File: rtl/icache_saturation_detector.sv
module icache_saturation_detector #(
  parameter int unsigned CNT_W = icsd_pkg::ICSD_CNT_W,
  parameter int unsigned WIN   = icsd_pkg::ICSD_WIN,
  localparam int unsigned POP_W = $clog2(WIN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lookup_vld_i,
  input  logic             lookup_miss_i,
  input  logic             migrate_done_i,
  input  logic [CNT_W-1:0] fill_thresh_i,
  input  logic [POP_W-1:0] dil_thresh_i,
  output logic             cache_full_o,
  output logic             new_seg_o,
  output logic             search_en_o
);
  logic [CNT_W-1:0] fill_thr_q, fill_thr_d;
  logic [POP_W-1:0] dil_thr_q, dil_thr_d;
  logic             cfg_vld_q;
  logic             cfg_en;

  logic [CNT_W-1:0] miss_cnt;
  logic [WIN-1:0]   win_vec;
  logic [POP_W-1:0] win_pop;
  logic             track_en;
  logic             seg_hit;

  // Threshold capture: once, on the first edge after reset release
  always_comb begin
    cfg_en     = ~cfg_vld_q;
    fill_thr_d = fill_thresh_i;
    dil_thr_d  = dil_thresh_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_thr_q <= '0;
      dil_thr_q  <= '0;
      cfg_vld_q  <= 1'b0;
    end else if (cfg_en) begin
      fill_thr_q <= fill_thr_d;
      dil_thr_q  <= dil_thr_d;
      cfg_vld_q  <= 1'b1;
    end
  end

  icsd_miss_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (migrate_done_i),
    .inc_i  (lookup_vld_i & lookup_miss_i),
    .cnt_o  (miss_cnt)
  );

  icsd_miss_window #(.WIN(WIN), .POP_W(POP_W)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (migrate_done_i),
    .shift_i (lookup_vld_i & track_en),
    .bit_i   (lookup_miss_i),
    .vec_o   (win_vec),
    .pop_o   (win_pop)
  );

  always_comb begin
    track_en = cfg_vld_q & (miss_cnt >= fill_thr_q);
    seg_hit  = track_en & (win_pop >= dil_thr_q);
  end

  assign cache_full_o = track_en;
  assign new_seg_o    = seg_hit;
  assign search_en_o  = seg_hit & ~migrate_done_i;
endmodule

// File: rtl/icsd_checker.sv
module icsd_checker #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned WIN   = 32,
  parameter int unsigned POP_W = $clog2(WIN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lookup_vld_i,
  input logic             lookup_miss_i,
  input logic             migrate_done_i,
  input logic             cache_full_o,
  input logic             new_seg_o,
  input logic             search_en_o,
  input logic [CNT_W-1:0] miss_cnt,
  input logic [WIN-1:0]   win_vec,
  input logic [CNT_W-1:0] fill_thr_q,
  input logic [POP_W-1:0] dil_thr_q,
  input logic             cfg_vld_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !migrate_done_i |=> (miss_cnt == $past(miss_cnt)) ||
                        (miss_cnt == CNT_W'($past(miss_cnt) + CNT_W'(1))));

  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lookup_vld_i && !migrate_done_i) |=> $stable(miss_cnt) && $stable(win_vec));

  assert_no_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_cnt == CNT_MAX && lookup_vld_i && lookup_miss_i && !migrate_done_i)
      |=> miss_cnt == CNT_MAX);

  assert_window_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cache_full_o && !migrate_done_i) |=> $stable(win_vec));

  assert_seg_needs_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_seg_o |-> cache_full_o);

  assert_search_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    migrate_done_i |-> !search_en_o);

  assert_migrate_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    migrate_done_i |=> (miss_cnt == '0) && (win_vec == '0));

  assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_vld_q |=> cfg_vld_q && $stable(fill_thr_q) && $stable(dil_thr_q));
endmodule

bind icache_saturation_detector icsd_checker #(.CNT_W(CNT_W), .WIN(WIN)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lookup_vld_i   (lookup_vld_i),
  .lookup_miss_i  (lookup_miss_i),
  .migrate_done_i (migrate_done_i),
  .cache_full_o   (cache_full_o),
  .new_seg_o      (new_seg_o),
  .search_en_o    (search_en_o),
  .miss_cnt       (miss_cnt),
  .win_vec        (win_vec),
  .fill_thr_q     (fill_thr_q),
  .dil_thr_q      (dil_thr_q),
  .cfg_vld_q      (cfg_vld_q)
);

// File: tb/icache_saturation_detector_tb.sv
`timescale 1ns/1ps
module icache_saturation_detector_tb_top;
  localparam int CNT_W = 10;
  localparam int WIN   = 32;
  localparam int POP_W = 6;
  localparam int CMAX  = 1023;

  logic clk = 1'b0;
  logic rst_n;
  logic vld, miss, mig;
  logic [CNT_W-1:0] fill_in;
  logic [POP_W-1:0] dil_in;
  logic full_o, seg_o, srch_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // bench reference state
  int           m_cnt;
  logic [31:0]  m_win;
  int           m_fill, m_dil;
  bit           m_cfg;

  always #2.5 clk = ~clk;

  icache_saturation_detector #(.CNT_W(CNT_W), .WIN(WIN)) dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .lookup_vld_i   (vld),
    .lookup_miss_i  (miss),
    .migrate_done_i (mig),
    .fill_thresh_i  (fill_in),
    .dil_thresh_i   (dil_in),
    .cache_full_o   (full_o),
    .new_seg_o      (seg_o),
    .search_en_o    (srch_o)
  );

  function automatic int ones(logic [31:0] v);
    int c = 0;
    for (int i = 0; i < 32; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic chk(logic act, logic exp, string tag, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic do_reset(int f, int d);
    @(negedge clk);
    rst_n = 1'b0; vld = 1'b0; miss = 1'b0; mig = 1'b0;
    fill_in = CNT_W'(f); dil_in = POP_W'(d);
    repeat (2) @(negedge clk);
    chk(full_o, 1'b0, "R9", "cache_full in reset");
    chk(seg_o,  1'b0, "R9", "new_seg in reset");
    chk(srch_o, 1'b0, "R9", "search_en in reset");
    rst_n = 1'b1;
    m_cnt = 0; m_win = '0; m_cfg = 1'b0;
  endtask

  // one cycle: drive, clock, update reference, compare outputs
  task automatic step(bit v, bit m, bit g);
    bit full_old, e_full, e_seg;
    vld = v; miss = m; mig = g;
    @(posedge clk);
    full_old = m_cfg && (m_cnt >= m_fill);
    if (!m_cfg) begin
      m_fill = int'(fill_in); m_dil = int'(dil_in); m_cfg = 1'b1;
    end
    if (g) begin
      m_cnt = 0; m_win = '0;
    end else if (v) begin
      if (full_old) m_win = {m_win[30:0], m};
      if (m && m_cnt != CMAX) m_cnt++;
    end
    @(negedge clk);
    e_full = m_cfg && (m_cnt >= m_fill);
    e_seg  = e_full && (ones(m_win) >= m_dil);
    chk(full_o, e_full, "R3", "cache_full");
    chk(seg_o,  e_seg,  "R5", "new_seg");
    chk(srch_o, e_seg && !g, "R6", "search_en");
    mig = 1'b0;
  endtask

  initial begin
    #(5ns * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; vld = 1'b0; miss = 1'b0; mig = 1'b0;
    fill_in = '0; dil_in = '0;

    // R1: exact threshold crossing, with hits and idle cycles ignored
    do_reset(6, 40 > WIN ? WIN : 2);
    step(0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      step(1, 1, 0); step(1, 0, 0); step(0, 1, 0);
    end
    chk(full_o, 1'b0, "R1", "full after five misses");
    step(1, 1, 0);
    chk(full_o, 1'b1, "R1", "full at sixth miss");

    // R4: misses before full are not recorded; sliding edge at 32
    do_reset(4, 3);
    step(0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 1, 0);
    chk(full_o, 1'b1, "R4", "full after four misses");
    chk(seg_o,  1'b0, "R4", "pre-full misses kept out of window");
    step(1, 1, 0); step(1, 1, 0);
    chk(seg_o, 1'b0, "R4", "two window misses below threshold");
    step(1, 1, 0);
    chk(seg_o, 1'b1, "R4", "three window misses reach threshold");
    for (int i = 0; i < 29; i++) step(1, 0, 0);
    chk(seg_o, 1'b1, "R4", "oldest miss still at bit 31");
    step(1, 0, 0);
    chk(seg_o, 1'b0, "R4", "oldest miss shifted out");

    // R6 and R7: migrate in the same cycle as a search, then cleared
    for (int i = 0; i < 3; i++) step(1, 1, 0);
    chk(srch_o, 1'b1, "R6", "search enabled before migrate");
    @(negedge clk);
    mig = 1'b1; vld = 1'b1; miss = 1'b1;
    #1;
    chk(srch_o, 1'b0, "R6", "search held low while migrate high");
    step(1, 1, 1);
    chk(full_o, 1'b0, "R7", "full cleared by migrate");
    chk(seg_o,  1'b0, "R7", "new_seg cleared by migrate");
    for (int i = 0; i < 3; i++) step(1, 1, 0);
    chk(full_o, 1'b0, "R7", "count restarted from zero");
    step(1, 1, 0);
    chk(full_o, 1'b1, "R7", "full again after four new misses");

    // R8: threshold changes after reset release are ignored
    do_reset(8, 2);
    step(0, 0, 0);
    fill_in = CNT_W'(1); dil_in = POP_W'(0);
    for (int i = 0; i < 3; i++) step(1, 1, 0);
    chk(full_o, 1'b0, "R8", "late fill threshold ignored");
    for (int i = 0; i < 5; i++) step(1, 1, 0);
    chk(full_o, 1'b1, "R8", "captured fill threshold used");
    chk(seg_o,  1'b0, "R8", "late dilution threshold ignored");

    // R10 and R2: top threshold, then saturation past it
    do_reset(CMAX, WIN);
    step(0, 0, 0);
    for (int i = 0; i < CMAX - 1; i++) step(1, 1, 0);
    chk(full_o, 1'b0, "R10", "one miss short of 1023");
    step(1, 1, 0);
    chk(full_o, 1'b1, "R10", "full at 1023 misses");
    for (int i = 0; i < 100; i++) step(1, 1, 0);
    chk(full_o, 1'b1, "R2", "count saturates, no wrap");
    chk(seg_o,  1'b1, "R10", "dilution threshold of 32 reached");

    // random rounds across the stated threshold ranges and densities
    for (int r = 0; r < 12; r++) begin
      int f, d, pct;
      f   = 128 + int'($urandom % 385);
      d   = 2 + int'($urandom % 29);
      pct = (r % 4 == 0) ? 15 : (r % 4 == 1) ? 45 : (r % 4 == 2) ? 75 : 95;
      do_reset(f, d);
      for (int i = 0; i < 3000; i++) begin
        bit v, m, g;
        v = ($urandom % 100) < 85;
        m = ($urandom % 100) < pct;
        g = ($urandom % 1500) == 0;
        step(v, m, g);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule